// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Serial Slave

This block is the bus-facing end of a small configurable peripheral on a two-wire I2C-compatible bus. It oversamples SCL and SDA with the system clock and recognises start and stop conditions. It collects the first byte after a start and compares its upper seven bits with its own address. It then acknowledges and moves whole bytes between the bus and a command layer behind it. The command layer sees each written byte as a one-cycle strobe with the data. For reads it is asked for each byte to transmit by a one-cycle request.

The device address is not programmed. It is chosen by a three-level board strap, which is captured while reset is held. A busy input from the command layer makes the slave decline every acknowledge slot. A master therefore sees a NACK and backs off while the peripheral cannot accept traffic.

Top module: `i2c_strap_slave`

## Requirements
- R1: SDA falling while SCL is high starts a new transaction from any state, including a repeated start inside a transfer. SDA rising while SCL is high returns the slave to idle. After a stop, bus activity gets no acknowledge until a new start.
- R2: The strap is sampled while rst_n is low and held afterwards. Strap code 2'b10 (tied high) selects address 7'h28. Codes 2'b01 (floating) and 2'b11 select 7'h2A. Code 2'b00 (tied low) selects 7'h2B. Changing the strap after reset has no effect.
- R3: The first byte after a start carries the address in bits 7..1, sent MSB first, and R/W in bit 0, where 1 means the master reads. When the address matches and busy is low, the slave pulls SDA low through the whole high phase of the ninth SCL pulse.
- R4: A non-matching address, including the general-call address 7'h00, gets no acknowledge. The slave ignores all further bytes until the next start.
- R5: In a write, each data byte is assembled MSB first. It is presented on rx_data_o with a single-cycle rx_valid_o pulse and acknowledged on its ninth pulse.
- R6: In a read, tx_req_o pulses once during the ninth pulse of the address byte, and once on each master ACK. The byte on tx_data_i is then shifted out MSB first, starting after that SCL falls.
- R7: A master NACK (SDA high) on the ninth pulse of a read byte ends the transfer. SDA stays released, no further byte is requested, and sel_o drops.
- R8: While busy_i is high, every slave acknowledge slot (address and write data) is left released, and no rx_valid_o pulse is issued.
- R9: sda_oe_o changes only while the synchronised SCL is low.
- R10: During reset sda_oe_o, rx_valid_o, tx_req_o and sel_o are all low.
- R11: sel_o is high from the address acknowledge until a stop, a new start, or a master NACK. rx_valid_o never pulses while sel_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset; strap is captured while low |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Address strap: 00 low, 01 floating, 10 high, 11 as floating |
| busy_i | input | 1 | Command layer busy; suppresses all acknowledges |
| rx_data_o | output | 8 | Last byte written by the master |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_data_i | input | 8 | Next byte to send on a read |
| tx_req_o | output | 1 | One-cycle request for the next transmit byte |
| sel_o | output | 1 | Slave is addressed and in a transfer |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and the three strap addresses 7'h28, 7'h2A and 7'h2B. With these values every strap code, including the unused 2'b11, can be driven against its expected address. Neighbouring addresses and 7'h00 can be shown to be refused. A bus period of 40 system clocks keeps the synchroniser delay well inside each SCL half period. That leaves room to test repeated starts, a stop in the middle of an address, and busy rising between the address and data bytes.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   localparam logic [1:0] STRAP_LOW   = 2'b00;
   localparam logic [1:0] STRAP_FLOAT = 2'b01;
   localparam logic [1:0] STRAP_HIGH  = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[g] <= 1'b1;
                  sda_chain[g] <= 1'b1;
               end else begin
                  scl_chain[g] <= scl_chain[g-1];
                  sda_chain[g] <= sda_chain[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_chain[STAGES-1];
         sda_q <= sda_chain[STAGES-1];
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode
   import i2c_strap_pkg::*;
#(
   parameter logic [6:0] ADDR_HI  = 7'h28,
   parameter logic [6:0] ADDR_FLT = 7'h2A,
   parameter logic [6:0] ADDR_LO  = 7'h2B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_i,
   output logic [6:0] own_addr
);
   logic [1:0] strap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   always_comb begin
      unique case (strap_q)
         STRAP_HIGH: own_addr = ADDR_HI;
         STRAP_LOW:  own_addr = ADDR_LO;
         default:    own_addr = ADDR_FLT;
      endcase
   end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_strap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [6:0]        own_addr,
   input  logic              busy_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              tx_req,
   output logic              sel,
   output logic              tx_drive
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   eng_state_t        state;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              rnw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         cnt      <= '0;
         rnw      <= 1'b0;
         sda_oe   <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
         sel      <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
            sel    <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            sel    <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     if (shreg[BYTE_W-1:1] == own_addr && !busy_i) begin
                        sda_oe <= 1'b1;
                        rnw    <= shreg[0];
                        sel    <= 1'b1;
                        state  <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_rise && rnw) begin
                     tx_req <= 1'b1;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (rnw) begin
                        shreg  <= tx_data_i;
                        sda_oe <= ~tx_data_i[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     if (!busy_i) begin
                        sda_oe   <= 1'b1;
                        rx_data  <= shreg;
                        rx_valid <= 1'b1;
                        state    <= ST_RACK;
                     end else begin
                        sel   <= 1'b0;
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TACK;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     if (sda_s) begin
                        sel   <= 1'b0;
                        state <= ST_IDLE;
                     end else begin
                        tx_req <= 1'b1;
                     end
                  end else if (scl_fall) begin
                     shreg  <= tx_data_i;
                     sda_oe <= ~tx_data_i[BYTE_W-1];
                     cnt    <= '0;
                     state  <= ST_TX;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign tx_drive = (state == ST_TX);
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
   import i2c_strap_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_HI     = 7'h28,
   parameter logic [6:0] ADDR_FLT    = 7'h2A,
   parameter logic [6:0] ADDR_LO     = 7'h2B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [1:0] strap_i,
   input  logic       busy_i,
   output logic [7:0] rx_data_o,
   output logic       rx_valid_o,
   input  logic [7:0] tx_data_i,
   output logic       tx_req_o,
   output logic       sel_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_HI == 7'h00 || ADDR_FLT == 7'h00 || ADDR_LO == 7'h00) begin : g_bad_gc
         $error("strap addresses must not be the general-call address");
      end
      if (ADDR_HI == ADDR_FLT || ADDR_HI == ADDR_LO || ADDR_FLT == ADDR_LO) begin : g_bad_dup
         $error("strap addresses must be distinct");
      end
   endgenerate

   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [6:0] own_addr;
   logic       tx_drive;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_strap_decode #(
      .ADDR_HI  (ADDR_HI),
      .ADDR_FLT (ADDR_FLT),
      .ADDR_LO  (ADDR_LO)
   ) strap_i0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_i  (strap_i),
      .own_addr (own_addr)
   );

   i2c_byte_engine eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_addr),
      .busy_i    (busy_i),
      .tx_data_i (tx_data_i),
      .sda_oe    (sda_oe_o),
      .rx_data   (rx_data_o),
      .rx_valid  (rx_valid_o),
      .tx_req    (tx_req_o),
      .sel       (sel_o),
      .tx_drive  (tx_drive)
   );
endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe_o,
   input logic busy_i,
   input logic rx_valid_o,
   input logic tx_req_o,
   input logic sel_o,
   input logic tx_drive
);
   // R10
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!sda_oe_o && !rx_valid_o && !tx_req_o && !sel_o);
      end
   end

   // R9
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

   // R5
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R6
   tx_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |=> !tx_req_o);

   // R8
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe_o) && !tx_drive) |-> !$past(busy_i));

   // R8
   busy_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> !$past(busy_i));

   // R11
   rx_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> sel_o);
endmodule

bind i2c_strap_slave i2c_strap_slave_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .sda_oe_o   (sda_oe_o),
   .busy_i     (busy_i),
   .rx_valid_o (rx_valid_o),
   .tx_req_o   (tx_req_o),
   .sel_o      (sel_o),
   .tx_drive   (tx_drive)
);

// File: tb/i2c_strap_slave_tb_top.sv
module i2c_strap_slave_tb_top;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       busy = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       sda_oe, rx_valid, tx_req, sel;
   logic [7:0] rx_data;
   wire        sda_line = sda_m & ~sda_oe;

   int n_checks = 0;
   int n_fail = 0;
   int rx_cnt = 0;
   logic [7:0] rx_last = 8'h00;
   int req_cnt = 0;
   logic [7:0] tx_bytes [4] = '{8'hD2, 8'h4B, 8'h80, 8'h3F};
   int oe_bad = 0;
   logic oe_prev = 1'b0;

   always #2 clk = ~clk;

   i2c_strap_slave dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_oe_o   (sda_oe),
      .strap_i    (strap),
      .busy_i     (busy),
      .rx_data_o  (rx_data),
      .rx_valid_o (rx_valid),
      .tx_data_i  (tx_data),
      .tx_req_o   (tx_req),
      .sel_o      (sel)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  = rx_cnt + 1;
         rx_last = rx_data;
      end
      if (tx_req) begin
         tx_data = tx_bytes[req_cnt % 4];
         req_cnt = req_cnt + 1;
      end
      if (sda_oe != oe_prev && scl_m) oe_bad = oe_bad + 1;
      oe_prev = sda_oe;
   end

   // fields: [18:17] strap, [16:10] address, [9] busy, [8:1] data, [0] expected ack
   localparam logic [18:0] VEC [8] = '{
      {2'b10, 7'h28, 1'b0, 8'hA5, 1'b1},
      {2'b10, 7'h2A, 1'b0, 8'h11, 1'b0},
      {2'b01, 7'h2A, 1'b0, 8'h3C, 1'b1},
      {2'b11, 7'h2A, 1'b0, 8'hC3, 1'b1},
      {2'b00, 7'h2B, 1'b0, 8'h7E, 1'b1},
      {2'b00, 7'h28, 1'b0, 8'h01, 1'b0},
      {2'b00, 7'h00, 1'b0, 8'h55, 1'b0},
      {2'b10, 7'h28, 1'b1, 8'h99, 1'b0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      scl_m = 1'b1;
      sda_m = 1'b1;
      wclk(5);
      rst_n = 1'b1;
      wclk(3);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      sda_m = 1'b0; wclk(Q);
      scl_m = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      sda_m = 1'b1; wclk(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wclk(Q);
      scl_m = 1'b1; wclk(2 * Q);
      scl_m = 1'b0; wclk(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      b = sda_line; wclk(Q);
      scl_m = 1'b0; wclk(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic nb;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(nb);
      ack = ~nb;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~m_ack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] d;
      // R10 reset state
      wclk(3);
      check(!sda_oe && !rx_valid && !tx_req && !sel, "R10", {sda_oe, rx_valid, tx_req, sel}, 0);

      // table walk: R2 R3 R4 R5 R8
      for (int v = 0; v < 8; v++) begin
         strap = VEC[v][18:17];
         busy  = VEC[v][9];
         do_reset();
         rx_cnt = 0;
         bus_start();
         send_byte({VEC[v][16:10], 1'b0}, ack);
         check(ack == VEC[v][0], "R2/R3/R4/R8 address ack", ack, VEC[v][0]);
         send_byte(VEC[v][8:1], ack);
         check(ack == VEC[v][0], "R4/R5/R8 data ack", ack, VEC[v][0]);
         bus_stop();
         check(rx_cnt == (VEC[v][0] ? 1 : 0), "R5/R8 rx count", rx_cnt, VEC[v][0]);
         if (VEC[v][0]) check(rx_last == VEC[v][8:1], "R5 rx data", rx_last, VEC[v][8:1]);
      end
      busy = 1'b0;

      // R2 strap change after reset ignored
      strap = 2'b10; do_reset(); strap = 2'b00;
      bus_start(); send_byte({7'h2B, 1'b0}, ack); bus_stop();
      check(!ack, "R2 late strap ignored", ack, 0);
      bus_start(); send_byte({7'h28, 1'b0}, ack); bus_stop();
      check(ack, "R2 latched address kept", ack, 1);
      strap = 2'b10;

      // R5 multi-byte write, R11 sel
      rx_cnt = 0;
      bus_start(); send_byte({7'h28, 1'b0}, ack);
      check(sel, "R11 sel after address ack", sel, 1);
      send_byte(8'h12, ack); send_byte(8'hF0, ack);
      check(ack && rx_last == 8'hF0, "R5 second byte", rx_last, 8'hF0);
      send_byte(8'h0F, ack);
      bus_stop();
      check(rx_cnt == 3 && rx_last == 8'h0F, "R5 three bytes", rx_cnt, 3);
      check(!sel, "R11 sel after stop", sel, 0);

      // R6 R7 read with master NACK
      req_cnt = 0;
      bus_start(); send_byte({7'h28, 1'b1}, ack);
      check(ack, "R3 read address ack", ack, 1);
      recv_byte(1'b1, d);
      check(d == 8'hD2, "R6 first read byte", d, 8'hD2);
      recv_byte(1'b0, d);
      check(d == 8'h4B, "R6 second read byte", d, 8'h4B);
      wclk(Q);
      check(!sda_oe && !sel, "R7 released after NACK", {sda_oe, sel}, 0);
      check(req_cnt == 2, "R7 no request after NACK", req_cnt, 2);
      bus_stop();

      // R8 busy raised between address and data
      rx_cnt = 0;
      bus_start(); send_byte({7'h28, 1'b0}, ack);
      busy = 1'b1;
      send_byte(8'h66, ack);
      check(!ack && rx_cnt == 0, "R8 data refused while busy", {ack, rx_cnt[0]}, 0);
      bus_stop();
      bus_start(); send_byte({7'h28, 1'b1}, ack); bus_stop();
      check(!ack, "R8 read address refused while busy", ack, 0);
      busy = 1'b0;

      // R1 repeated start into read
      req_cnt = 0;
      bus_start(); send_byte({7'h28, 1'b0}, ack); send_byte(8'h44, ack);
      bus_start(); send_byte({7'h28, 1'b1}, ack);
      check(ack, "R1 repeated start address ack", ack, 1);
      recv_byte(1'b0, d);
      check(d == 8'hD2, "R1 read after repeated start", d, 8'hD2);
      bus_stop();

      // R1 stop inside address byte
      bus_start();
      for (int i = 7; i >= 4; i--) send_bit(7'h28 >> (i - 1));
      bus_stop();
      send_byte({7'h28, 1'b0}, ack);
      check(!ack, "R1 idle after stop", ack, 0);
      bus_start(); send_byte({7'h28, 1'b0}, ack); bus_stop();
      check(ack, "R1 new start accepted", ack, 1);

      // R9 SDA driver only moves with SCL low
      check(oe_bad == 0, "R9 oe change during SCL high", oe_bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule